// File: doc/BRIEF.md
# Card Presence Debounce Filter

This block cleans up the mechanical card-detect switch of a smart-card slot. The raw detect level is brought into the clock domain by two flip-flops. A change of level is accepted only after the synchronized input has held the new level for a programmable number of time units. The time unit is longer for insertion than for extraction. A card then counts as present only once the contacts have clearly settled, while a removal is seen quickly.

The block keeps one filtered presence bit. Each accepted change sets a sticky event flag. The flag is cleared by a read strobe from the interrupt register, and it drives an interrupt line unless the mask bit is set. A bounce shorter than the programmed window restarts the timer and leaves the presence bit and the flag untouched.

Top module: `card_detect_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, `present_o`, `cd_flag_o` and `cd_irq_o` are 0. The presence bit uses 1 for a card and 0 for no card.
- R2: Let L = (`dly_i`+1)*INS_UNIT, where `dly_i` is an unsigned 4-bit value. A 0-to-1 change of `cd_raw_i` that then holds is accepted on exactly the (L+2)-th rising edge after the change. `present_o` is unchanged after edge L+1 and is 1 after edge L+2. Two of these edges are synchronizer delay.
- R3: A 1-to-0 change is accepted in the same way with L = (`dly_i`+1)*EXT_UNIT.
- R4: If the input returns to the accepted level after fewer than L cycles of disagreement, nothing changes. The timer restarts from zero, and neither `present_o` nor `cd_flag_o` changes.
- R5: `cd_flag_o` goes to 1 on the same edge on which `present_o` changes, for both directions.
- R6: A one-cycle `cd_rd_i` pulse clears `cd_flag_o` on the next edge. If a new change is accepted on that same edge, the flag stays 1.
- R7: `cd_irq_o` equals `cd_flag_o` when `cd_mask_i` is 0 and is 0 when `cd_mask_i` is 1.
- R8: With `dly_i` = 0 a change is accepted after exactly one unit (L = unit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cd_raw_i | input | 1 | Raw card-detect level, asynchronous |
| dly_i | input | DLY_W | Filter delay in units, minus one |
| cd_mask_i | input | 1 | 1 disables the card-detect interrupt |
| cd_rd_i | input | 1 | Read strobe of the interrupt register, clears the flag |
| present_o | output | 1 | Filtered presence, 1 = card detected |
| cd_flag_o | output | 1 | Sticky insertion/extraction event flag |
| cd_irq_o | output | 1 | Masked interrupt request |

## Verification
The bench checks the exact acceptance edge L+2 against L+1 for both directions. A design that miscounted the synchronizer stages or used the wrong unit for a direction would flip one cycle early or late, or hundreds of cycles off. Bounces of length L-1 are driven to catch a filter that accepts too early or does not restart its timer. A read strobe is placed on the very edge where a change is accepted. This exposes a flag whose clear wins over the set, which would lose the event. Masked and unmasked events check that the mask gates only the interrupt line and not the flag.

// File: rtl/card_detect_filter.sv
module card_detect_filter #(
  parameter int DLY_W    = 4,
  parameter int EXT_UNIT = 1024,
  parameter int INS_UNIT = 8192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cd_raw_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             cd_mask_i,
  input  logic             cd_rd_i,
  output logic             present_o,
  output logic             cd_flag_o,
  output logic             cd_irq_o
);

  localparam int MAX_LIM = (2 ** DLY_W) * INS_UNIT;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic             s1, s2, present, flag;
  logic [CNT_W-1:0] cnt, lim;
  logic             mism, hit;

  assign mism = s2 ^ present;
  assign lim  = CNT_W'((32'(dly_i) + 32'd1) * 32'(s2 ? INS_UNIT : EXT_UNIT));
  // >= keeps a shrinking delay from stranding the count above the limit
  assign hit  = mism && (cnt >= lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      cnt     <= '0;
      present <= 1'b0;
      flag    <= 1'b0;
    end else begin
      s1 <= cd_raw_i;
      s2 <= s1;
      if (!mism || hit) cnt <= '0;
      else              cnt <= cnt + CNT_W'(1);
      if (hit) present <= s2;
      if (hit)          flag <= 1'b1;
      else if (cd_rd_i) flag <= 1'b0;
    end
  end

  assign present_o = present;
  assign cd_flag_o = flag;
  assign cd_irq_o  = flag & ~cd_mask_i;

  p_change_needs_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
    (present != $past(present)) |-> ($past(s2) != $past(present)));

  p_flag_on_change_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (present != $past(present)));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    cd_rd_i |=> (!flag || (present != $past(present))));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_LIM));

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!present && !flag));

endmodule

// File: tb/card_detect_filter_bench.sv
`timescale 1ns/1ps
module card_detect_filter_bench;
  localparam int EXT = 8;
  localparam int INS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic [3:0] dly = 4'd0;
  logic mask = 1'b0;
  logic rd = 1'b0;
  logic present, flag, irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  card_detect_filter #(.DLY_W(4), .EXT_UNIT(EXT), .INS_UNIT(INS)) u_card_detect_filter (
    .clk(clk), .rst(rst), .cd_raw_i(raw), .dly_i(dly), .cd_mask_i(mask),
    .cd_rd_i(rd), .present_o(present), .cd_flag_o(flag), .cd_irq_o(irq));

  function automatic int lim_of(bit ins, int d);
    return (d + 1) * (ins ? INS : EXT);
  endfunction

  function automatic bit exp_irq(bit f, bit m);
    return f & ~m;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R6 clear", flag, 0);
  endtask

  // full change; optional read strobe on the accepting edge
  task automatic full_change(bit lvl, int d, bit rd_on_hit, string req);
    int l = lim_of(lvl, d);
    bit old = present;
    dly = 4'(d);
    raw = lvl;
    repeat (l + 1) @(negedge clk);
    chk({req, " before edge L+2"}, present, old);
    chk({req, " flag quiet"}, flag, 0);
    if (rd_on_hit) rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk({req, " at edge L+2"}, present, lvl);
    chk("R5 flag on change", flag, 1);
    chk("R7 irq", irq, exp_irq(1'b1, mask));
  endtask

  task automatic glitch(int g, string req);
    bit old = present;
    raw = ~old;
    repeat (g) @(negedge clk);
    raw = old;
    repeat (lim_of(~old, int'(dly)) + 4) @(negedge clk);
    chk({req, " glitch ignored"}, present, old);
    chk({req, " no flag"}, flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset present", present, 0);
    chk("R1 reset flag", flag, 0);
    chk("R1 reset irq", irq, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", present, 0);

    full_change(1'b1, 0, 1'b0, "R8 R2 insert d0");
    clear_flag();
    full_change(1'b0, 0, 1'b0, "R8 R3 extract d0");
    clear_flag();
    full_change(1'b1, 3, 1'b0, "R2 insert d3");
    clear_flag();
    dly = 4'd2;
    glitch(lim_of(1'b0, 2) - 1, "R4 extract L-1");
    mask = 1'b1;
    full_change(1'b0, 2, 1'b0, "R3 extract masked");
    chk("R7 masked irq", irq, 0);
    mask = 1'b0;
    @(negedge clk);
    chk("R7 unmask irq", irq, 1);
    clear_flag();
    chk("R7 irq after clear", irq, 0);
    full_change(1'b1, 1, 1'b1, "R6 set wins over read");
    clear_flag();

    for (int i = 0; i < 24; i++) begin
      int d = int'($urandom_range(0, 15));
      mask = 1'($urandom_range(0, 1));
      dly = 4'(d);
      if ($urandom_range(0, 2) == 0) begin
        glitch(int'($urandom_range(1, lim_of(~present, d) - 1)), "R4 random");
      end else begin
        full_change(~present, d, 1'b0, present ? "R3 random" : "R2 random");
        clear_flag();
      end
      repeat (3) @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule